// File: doc/BRIEF.md
# Serial NOR Flash Bus-Protocol Identification Probe

This block runs once at boot, or whenever software wants to rediscover the flash, to find out which bus protocol an attached serial NOR flash currently expects. The flash may have been left in a dual-lane or quad-lane command mode by a non-volatile setting or by an earlier boot stage. The block walks through a fixed, ordered list of identification-read attempts. Each attempt pairs an opcode with a lane width, and each is handed to an external multi-lane SPI transaction engine. After each attempt the block inspects the first three bytes that come back. A flash that does not understand the opcode or the lane width leaves the data lines undriven, so they settle at the pull-up or pull-down level. The reply then reads as all ones or all zeros. Such a reply is taken to mean that no device answered.

The first plausible reply ends the probe. The protocol of that attempt becomes the working protocol of all four command classes: register access, read, write and erase. The identification bytes are presented on a flat output vector. An input chooses whether the board supports quad-lane or dual-lane operation, and attempts of the other lane class are skipped. An engine error aborts the probe at once. Matching the returned ID against a part list is left to software.

Top module: `flash_id_probe`

## Requirements
- R1: After reset, `done`, `found`, `err` and `req_valid` are 0, `id_bytes` is all zero and all four class protocol outputs hold 0x111.
- R2: A protocol code places the command lane count in bits [11:8], the address lane count in bits [7:4] and the data lane count in bits [3:0]. The candidate attempts, in this order, are: attempt 0 = code 0x111, opcode 0x9F, 6 bytes; attempt 1 = 0x444, 0x9F, 6 bytes; attempt 2 = 0x444, 0xAF, 3 bytes; attempt 3 = 0x222, 0xAF, 3 bytes.
- R3: Attempt 0 is always issued. With `mode_quad`=1, attempts 1 and 2 may be issued and attempt 3 is skipped. With `mode_quad`=0, attempts 1 and 2 are skipped and attempt 3 may be issued. A skipped attempt produces no request.
- R4: A reply is plausible when its first three bytes, taken as one 24-bit value, are neither 0x000000 nor 0xFFFFFF. Any other pattern, such as FF FF 00, counts as plausible.
- R5: The probe stops at the first plausible reply. It then raises `done` with `found`=1 and loads the attempt's protocol code into all four class protocol outputs.
- R6: Returned byte k appears at `id_bytes[8k+7:8k]`. Every issued attempt clears all ID positions. Bytes beyond the requested count are discarded, so positions 3 to 5 stay zero after a 3-byte attempt.
- R7: If no issued attempt gives a plausible reply, the block raises `done` with `found`=0 and `err`=0, and the class protocols stay at 0x111.
- R8: An `eng_err` during an attempt ends the probe. The block raises `done` with `err`=1 and `found`=0 and issues no further request.
- R9: All four class protocol outputs return to 0x111 by the cycle after `start` is accepted.
- R10: `done` is a one-cycle pulse. Its latency is counted in rising edges from the edge that samples the last engine completion. The latency is 1 after an error and 2 after a plausible reply. With no plausible reply it is 3 when attempt 3 was the last one issued, and 5 when attempt 2 was the last one issued (quad mode).
- R11: Each issued attempt raises `req_valid` for exactly one cycle, and the request fields are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a probe (accepted while idle) |
| mode_quad | input | 1 | 1: quad-lane attempts allowed; 0: dual-lane attempts allowed |
| req_valid | output | 1 | One-cycle request to the transaction engine |
| req_opcode | output | 8 | ID-read opcode of the request |
| req_proto | output | 12 | Protocol code of the request |
| req_len | output | 3 | Number of reply bytes requested |
| eng_byte_valid | input | 1 | A reply byte is present |
| eng_byte | input | 8 | Reply byte |
| eng_done | input | 1 | Engine finished the current request |
| eng_err | input | 1 | Engine failed the current request |
| done | output | 1 | One-cycle end-of-probe pulse |
| found | output | 1 | A plausible ID was read |
| err | output | 1 | The probe was aborted by an engine error |
| id_bytes | output | 48 | Identification bytes, byte 0 in the low bits |
| proto_reg | output | 12 | Working protocol for register commands |
| proto_rd | output | 12 | Working protocol for read commands |
| proto_wr | output | 12 | Working protocol for write commands |
| proto_er | output | 12 | Working protocol for erase commands |

## Verification
Each engine completion is counted by rising edges until `done` appears. The bench computes the expected latency (1, 2, 3 or 5 edges) from the outcome its reference model predicts for the attempt list. It samples every falling edge in between and flags a `done` that comes early or late. The bench also checks the class protocols on the falling edge right after `start`, one edge after acceptance. It checks each request on the falling edge of its `req_valid` cycle, and the result outputs on the falling edge where `done` is high.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

  typedef logic [11:0] proto_t;

  localparam proto_t PROTO_1L = 12'h111;
  localparam proto_t PROTO_2L = 12'h222;
  localparam proto_t PROTO_4L = 12'h444;

  localparam logic [7:0] OP_ID_STD   = 8'h9F;
  localparam logic [7:0] OP_ID_MULTI = 8'hAF;

  localparam int N_ATTEMPTS = 4;
  localparam int N_CLASSES  = 4;
  localparam int SHORT_LEN  = 3;

  typedef enum logic [1:0] {
    LANES_ANY  = 2'd0,
    LANES_DUAL = 2'd1,
    LANES_QUAD = 2'd2
  } lane_cls_t;

  typedef struct packed {
    logic [7:0] opcode;
    proto_t     proto;
    lane_cls_t  cls;
    logic       short_reply;
  } attempt_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_CHECK = 3'd3,
    ST_NEXT  = 3'd4,
    ST_DONE  = 3'd5
  } st_t;

endpackage

// File: rtl/probe_attempt_table.sv
module probe_attempt_table
  import flash_probe_pkg::*;
(
  input  logic [1:0] idx,
  output attempt_t   att
);

  always_comb begin
    unique case (idx)
      2'd0: att = '{opcode: OP_ID_STD,   proto: PROTO_1L, cls: LANES_ANY,  short_reply: 1'b0};
      2'd1: att = '{opcode: OP_ID_STD,   proto: PROTO_4L, cls: LANES_QUAD, short_reply: 1'b0};
      2'd2: att = '{opcode: OP_ID_MULTI, proto: PROTO_4L, cls: LANES_QUAD, short_reply: 1'b1};
      default: att = '{opcode: OP_ID_MULTI, proto: PROTO_2L, cls: LANES_DUAL, short_reply: 1'b1};
    endcase
  end

endmodule

// File: rtl/id_capture.sv
module id_capture #(
  parameter int ID_MAX = 6,
  parameter int CNT_W  = $clog2(ID_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  cap_en,
  input  logic                  byte_valid,
  input  logic [7:0]            byte_data,
  input  logic [CNT_W-1:0]      limit,
  output logic [ID_MAX*8-1:0]   id_bytes,
  output logic                  id_ok
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             take;

  assign take = cap_en && byte_valid && (cnt_q < limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)     cnt_d = '0;
    else if (take) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar k = 0; k < ID_MAX; k++) begin : g_slot
    logic [7:0] slot_q;
    logic       slot_en;
    assign slot_en = clear || (take && (cnt_q == CNT_W'(k)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= clear ? 8'h00 : byte_data;
    end
    assign id_bytes[8*k +: 8] = slot_q;
  end

  assign id_ok = (id_bytes[23:0] != 24'h000000) && (id_bytes[23:0] != 24'hFFFFFF);

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ID_MAX));

  p_drop_excess_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && cnt_q >= limit) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/probe_fsm.sv
module probe_fsm
  import flash_probe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mode_quad,
  input  attempt_t   att,
  input  logic       eng_done,
  input  logic       eng_err,
  input  logic       id_ok,
  output logic [1:0] idx,
  output logic       req_valid,
  output logic       clear_id,
  output logic       cap_en,
  output logic       latch_proto,
  output logic       clr_proto,
  output logic       done,
  output logic       found,
  output logic       err
);

  st_t        st_q, st_d;
  logic [1:0] idx_d;
  logic       found_d, err_d;
  logic       allowed;

  always_comb begin
    allowed = (att.cls == LANES_ANY)
           || ((att.cls == LANES_QUAD) &&  mode_quad)
           || ((att.cls == LANES_DUAL) && !mode_quad);
  end

  always_comb begin
    st_d        = st_q;
    idx_d       = idx;
    found_d     = found;
    err_d       = err;
    req_valid   = 1'b0;
    clear_id    = 1'b0;
    latch_proto = 1'b0;
    clr_proto   = 1'b0;
    cap_en      = (st_q == ST_WAIT);
    done        = (st_q == ST_DONE);
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d      = ST_ISSUE;
          idx_d     = 2'd0;
          found_d   = 1'b0;
          err_d     = 1'b0;
          clr_proto = 1'b1;
        end
      end
      ST_ISSUE: begin
        if (allowed) begin
          req_valid = 1'b1;
          clear_id  = 1'b1;
          st_d      = ST_WAIT;
        end else begin
          st_d = ST_NEXT;
        end
      end
      ST_WAIT: begin
        if (eng_err) begin
          err_d = 1'b1;
          st_d  = ST_DONE;
        end else if (eng_done) begin
          st_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (id_ok) begin
          found_d     = 1'b1;
          latch_proto = 1'b1;
          st_d        = ST_DONE;
        end else begin
          st_d = ST_NEXT;
        end
      end
      ST_NEXT: begin
        if (idx == 2'(N_ATTEMPTS - 1)) begin
          st_d = ST_DONE;
        end else begin
          idx_d = idx + 2'd1;
          st_d  = ST_ISSUE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx   <= 2'd0;
      found <= 1'b0;
      err   <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx   <= idx_d;
      found <= found_d;
      err   <= err_d;
    end
  end

  p_req_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_found_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(found && err));

  p_err_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && eng_err) |=> (done && err && !found));

  p_exhaust_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_NEXT && idx == 2'd3) |=> (done && !found && !err));

endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import flash_probe_pkg::*;
#(
  parameter int ID_MAX = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          mode_quad,
  output logic                          req_valid,
  output logic [7:0]                    req_opcode,
  output logic [11:0]                   req_proto,
  output logic [$clog2(ID_MAX+1)-1:0]   req_len,
  input  logic                          eng_byte_valid,
  input  logic [7:0]                    eng_byte,
  input  logic                          eng_done,
  input  logic                          eng_err,
  output logic                          done,
  output logic                          found,
  output logic                          err,
  output logic [ID_MAX*8-1:0]           id_bytes,
  output logic [11:0]                   proto_reg,
  output logic [11:0]                   proto_rd,
  output logic [11:0]                   proto_wr,
  output logic [11:0]                   proto_er
);

  localparam int CNT_W = $clog2(ID_MAX + 1);

  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  logic [1:0] idx;
  attempt_t   att;
  logic       clear_id, cap_en, latch_proto, clr_proto, id_ok;

  probe_attempt_table u_table (
    .idx (idx),
    .att (att)
  );

  probe_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .start       (start),
    .mode_quad   (mode_quad),
    .att         (att),
    .eng_done    (eng_done),
    .eng_err     (eng_err),
    .id_ok       (id_ok),
    .idx         (idx),
    .req_valid   (req_valid),
    .clear_id    (clear_id),
    .cap_en      (cap_en),
    .latch_proto (latch_proto),
    .clr_proto   (clr_proto),
    .done        (done),
    .found       (found),
    .err         (err)
  );

  assign req_opcode = att.opcode;
  assign req_proto  = att.proto;
  assign req_len    = att.short_reply ? CNT_W'(SHORT_LEN) : CNT_W'(ID_MAX);

  id_capture #(.ID_MAX(ID_MAX), .CNT_W(CNT_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .clear      (clear_id),
    .cap_en     (cap_en),
    .byte_valid (eng_byte_valid),
    .byte_data  (eng_byte),
    .limit      (req_len),
    .id_bytes   (id_bytes),
    .id_ok      (id_ok)
  );

  proto_t cls_proto [N_CLASSES];

  for (genvar c = 0; c < N_CLASSES; c++) begin : g_class
    logic cls_en;
    assign cls_en = clr_proto || latch_proto;
    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n)    cls_proto[c] <= PROTO_1L;
      else if (cls_en) cls_proto[c] <= clr_proto ? PROTO_1L : att.proto;
    end
  end

  assign proto_reg = cls_proto[0];
  assign proto_rd  = cls_proto[1];
  assign proto_wr  = cls_proto[2];
  assign proto_er  = cls_proto[3];

  p_proto_reset_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    clr_proto |=> (proto_reg == PROTO_1L && proto_rd == PROTO_1L &&
                   proto_wr == PROTO_1L && proto_er == PROTO_1L));

  p_found_id_valid_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done && found) |-> (id_bytes[23:0] != 24'h000000 && id_bytes[23:0] != 24'hFFFFFF));

  p_found_proto_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (done && found) |-> (proto_rd == proto_reg && proto_wr == proto_reg && proto_er == proto_reg));

  p_lane_filter_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    req_valid |-> (mode_quad ? (req_proto != PROTO_2L) : (req_proto != PROTO_4L)));

endmodule

// File: tb/tb_flash_id_probe.sv
module tb_flash_id_probe;
  import flash_probe_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int ID_MAX     = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, mode_quad;
  logic        req_valid;
  logic [7:0]  req_opcode;
  logic [11:0] req_proto;
  logic [2:0]  req_len;
  logic        eng_byte_valid, eng_done, eng_err;
  logic [7:0]  eng_byte;
  logic        done, found, err;
  logic [47:0] id_bytes;
  logic [11:0] proto_reg, proto_rd, proto_wr, proto_er;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_id_probe #(.ID_MAX(ID_MAX)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_quad(mode_quad),
    .req_valid(req_valid), .req_opcode(req_opcode), .req_proto(req_proto), .req_len(req_len),
    .eng_byte_valid(eng_byte_valid), .eng_byte(eng_byte), .eng_done(eng_done), .eng_err(eng_err),
    .done(done), .found(found), .err(err), .id_bytes(id_bytes),
    .proto_reg(proto_reg), .proto_rd(proto_rd), .proto_wr(proto_wr), .proto_er(proto_er)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_op(int i);
    return (i < 2) ? 8'h9F : 8'hAF;
  endfunction

  function automatic logic [11:0] ref_proto(int i);
    if (i == 0) return 12'h111;
    if (i == 3) return 12'h222;
    return 12'h444;
  endfunction

  function automatic int ref_len(int i);
    return (i < 2) ? 6 : 3;
  endfunction

  function automatic bit ref_allowed(int i, bit quad);
    return (i == 0) || (quad && (i == 1 || i == 2)) || (!quad && i == 3);
  endfunction

  function automatic bit ref_valid(logic [47:0] r);
    return (r[23:0] != 24'h000000) && (r[23:0] != 24'hFFFFFF);
  endfunction

  function automatic logic [47:0] ref_reply(int i, int ans, logic [47:0] pat, logic [7:0] fill);
    return (i == ans) ? pat : {6{fill}};
  endfunction

  task automatic check_protos(input string req, input logic [11:0] exp);
    check(proto_reg == exp, req, "proto_reg", 64'(proto_reg), 64'(exp));
    check(proto_rd  == exp, req, "proto_rd",  64'(proto_rd),  64'(exp));
    check(proto_wr  == exp, req, "proto_wr",  64'(proto_wr),  64'(exp));
    check(proto_er  == exp, req, "proto_er",  64'(proto_er),  64'(exp));
  endtask

  task automatic run_case(input bit quad, input int ans, input logic [47:0] pat,
                          input logic [7:0] fill, input int err_k, input bit extra);
    int          exp_seq[$];
    bit          exp_found = 0;
    bit          exp_err = 0;
    int          exp_hit = -1;
    int          exp_lat;
    logic [47:0] exp_id = '0;
    int          k = 0;
    int          guard = 0;
    bit          fin = 0;

    for (int i = 0; i < 4; i++) begin
      if (!ref_allowed(i, quad)) continue;
      exp_seq.push_back(i);
      if (exp_seq.size() - 1 == err_k) begin exp_err = 1; break; end
      if (ref_valid(ref_reply(i, ans, pat, fill))) begin exp_found = 1; exp_hit = i; break; end
    end
    if (exp_err)        exp_lat = 1;
    else if (exp_found) exp_lat = 2;
    else                exp_lat = (exp_seq[exp_seq.size()-1] == 3) ? 3 : 5;
    if (exp_found) begin
      logic [47:0] r = ref_reply(exp_hit, ans, pat, fill);
      for (int b = 0; b < ref_len(exp_hit); b++) exp_id[8*b +: 8] = r[8*b +: 8];
    end

    @(negedge clk);
    mode_quad = quad;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_protos("R9", 12'h111);

    while (!fin && guard < 200) begin
      guard++;
      if (req_valid) begin
        int          i;
        int          n;
        logic [47:0] r;
        check(k < exp_seq.size(), "R3", "unexpected request", 64'(k), 64'(exp_seq.size()));
        i = (k < exp_seq.size()) ? exp_seq[k] : 0;
        check(req_opcode == ref_op(i), "R2", "opcode", 64'(req_opcode), 64'(ref_op(i)));
        check(req_proto == ref_proto(i), "R2", "proto", 64'(req_proto), 64'(ref_proto(i)));
        check(int'(req_len) == ref_len(i), "R2", "len", 64'(req_len), 64'(ref_len(i)));
        r = ref_reply(i, ans, pat, fill);
        n = ref_len(i) + (extra ? 1 : 0);
        @(negedge clk);
        check(!req_valid, "R11", "req_valid width", 64'(req_valid), 64'(0));
        for (int b = 0; b < n; b++) begin
          eng_byte_valid = 1'b1;
          eng_byte = (b < ref_len(i)) ? r[8*b +: 8] : 8'h5A;
          @(negedge clk);
        end
        eng_byte_valid = 1'b0;
        if (k == err_k) eng_err = 1'b1; else eng_done = 1'b1;
        @(negedge clk);
        eng_err = 1'b0;
        eng_done = 1'b0;
        if (k == exp_seq.size() - 1) begin
          int lat = 1;
          while (!done && lat < 8) begin
            @(negedge clk);
            lat++;
          end
          check(lat == exp_lat, "R10", "done latency", 64'(lat), 64'(exp_lat));
          fin = 1;
        end
        k++;
      end else begin
        check(!done, "R10", "early done", 64'(done), 64'(0));
        @(negedge clk);
      end
    end

    check(k == exp_seq.size(), "R11", "request count", 64'(k), 64'(exp_seq.size()));
    check(found == exp_found, exp_found ? "R5" : "R7", "found", 64'(found), 64'(exp_found));
    check(err == exp_err, "R8", "err", 64'(err), 64'(exp_err));
    if (exp_found) begin
      check_protos("R5", ref_proto(exp_hit));
      check(id_bytes == exp_id, "R6", "id_bytes", 64'(id_bytes), 64'(exp_id));
    end else begin
      check_protos(exp_err ? "R8" : "R7", 12'h111);
    end
    @(negedge clk);
    check(!done, "R10", "done pulse", 64'(done), 64'(0));
    check(!req_valid, "R8", "request after end", 64'(req_valid), 64'(0));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    mode_quad = 1'b1;
    eng_byte_valid = 1'b0;
    eng_byte = 8'h00;
    eng_done = 1'b0;
    eng_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(!done && !found && !err, "R1", "flags", 64'({done, found, err}), 64'(0));
    check(!req_valid, "R1", "req_valid", 64'(req_valid), 64'(0));
    check(id_bytes == '0, "R1", "id_bytes", 64'(id_bytes), 64'(0));
    check_protos("R1", 12'h111);

    // R5: plain single-lane answer
    run_case(1'b1, 0, 48'h665544_1620C2, 8'hFF, -1, 1'b0);
    // R2/R5: quad command mode answering standard opcode
    run_case(1'b1, 1, 48'h000000_1840EF, 8'hFF, -1, 1'b0);
    // R6/R9: quad multi-lane opcode, extra byte must be dropped
    run_case(1'b1, 2, 48'hABCDEF_19BA20, 8'h00, -1, 1'b1);
    // R3: dual mode skips quad attempts
    run_case(1'b0, 3, 48'h000000_17BB20, 8'hFF, -1, 1'b1);
    // R7: quad mode, nobody answers, pull-ups
    run_case(1'b1, 3, 48'h000000_17BB20, 8'hFF, -1, 1'b0);
    // R7: dual mode, nobody answers, pull-downs
    run_case(1'b0, -1, 48'h0, 8'h00, -1, 1'b0);
    // R8: engine error on the second issued attempt
    run_case(1'b1, 2, 48'h000000_123456, 8'hFF, 1, 1'b0);
    // R4: leading zeros then data is not plausible
    run_case(1'b1, 0, 48'h998877_000000, 8'h00, -1, 1'b0);
    // R4: FF FF 00 is plausible
    run_case(1'b1, 1, 48'h000000_00FFFF, 8'hFF, -1, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule